// File: doc/BRIEF.md
# Phase-Shifted Complementary PWM Timer

This block generates one complementary pair of PWM pins whose phase is set against a free-running reference counter. A reference counter counts from zero up to a programmed terminal value and wraps. A follower counter has the same period and is restarted from zero by a selectable reference event: either the reference wrap or the reference counter reaching a programmed phase value. Three compare units watch the follower count. One chosen unit drives the internal waveform high, and another chosen unit drives it low. The high-side and low-side pins are derived from that waveform, with separate dead-time delays on each turn-on edge.

Software writes the terminal value and the phase value into shadow registers. These reach the reference counter only at its wrap, or at any time while the block is disabled, so a single phase value governs each reference period. A compare value of zero matches on every follower restart as well as on the natural wrap. Driving the waveform high with such a unit starts every follower cycle high, including a cycle that a phase step cuts short. When the set unit and the reset unit match in the same clock, the unit with the larger index wins. As a result, a phase step of exactly half a period can be made to keep the waveform high rather than lose a set edge.

Top module: `phase_pwm_timer`

## Requirements
- R1: While enabled, the reference counter steps by one each clock from 0 up to the active terminal value T and then wraps to 0, so one period lasts T+1 clocks and the same phase recurs every T+1 clocks.
- R2: Register writes use `wr_addr`: 0 terminal value, 1 phase value, 2/3/4 compare units 1/2/3, 5 mode, 6 rise delay, 7 fall delay. Compare, mode and delay writes take effect on the clock after the write.
- R3: The terminal and phase registers are shadowed. A phase write made mid-period does not move the restart in that period; it is first used after the next reference wrap.
- R4: Mode bit 0 selects the follower restart: 1 restarts when the reference counter becomes the phase value P, 0 restarts when it wraps to 0. With the set unit at value 0, the high pin turns on in the clock where the reference count equals (P + 1 + rise delay) mod (T+1).
- R5: A compare unit holding 0 matches on every follower restart and on every natural follower wrap. The set edge therefore occurs at the start of each follower cycle, including cycles shortened by a phase change.
- R6: Mode bits [2:1] name the set unit and bits [4:3] name the reset unit (1 to 3, 0 = none). If both match in one clock, the larger index wins, and set wins on equal indices.
- R7: While `en` is low, both pins are low and both counters are held at zero; after reset the pins are low.
- R8: A high-side pulse lasts the waveform's high time minus the rise delay. A low-side pulse lasts the waveform's low time minus the fall delay. The two pins are never high in the same clock.
- R9: With set on value 0 and reset at half a period, phase steps of 70%→30% and 10%→80% keep every high-side pulse at half a period minus the rise delay. No high-side pulse ever exceeds one period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces pins low and counters to zero |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CW | Write data |
| pwm_hi | output | 1 | High-side PWM pin |
| pwm_lo | output | 1 | Complementary low-side PWM pin |

## Verification
The pins are driven through steady phases, through the two large phase steps, and through a step of exactly half a period. That half-period step is run twice: once with the set unit outranking the reset unit and once the other way round. Only the priority rule explains why one run yields a single full-period high pulse and the other a full-period low pulse. A phase write made in the middle of a period shows whether the turn-on lands at the old phase or the new one, which separates shadow loading from immediate loading. Random phases and dead times then check turn-on position, pulse widths and the period spacing against values the bench computes from the programmed numbers.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned NUM_CMP = 3;

  localparam logic [ADDR_W-1:0] RA_TERM  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_PHASE = 3'd1;
  localparam logic [ADDR_W-1:0] RA_CMP1  = 3'd2;
  localparam logic [ADDR_W-1:0] RA_MODE  = 3'd5;
  localparam logic [ADDR_W-1:0] RA_DTR   = 3'd6;
  localparam logic [ADDR_W-1:0] RA_DTF   = 3'd7;

  localparam int unsigned MODE_W = 5;

  // unit index 0 means "no unit"; 1..NUM_CMP select a compare unit
  typedef struct packed {
    logic [1:0] rst_unit;
    logic [1:0] set_unit;
    logic       restart_on_phase;
  } mode_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned DTW = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [CW-1:0]                wr_data,
  output logic [CW-1:0]                term_sh,
  output logic [CW-1:0]                phase_sh,
  output logic [NUM_CMP-1:0][CW-1:0]   cmp_val,
  output mode_t                        mode,
  output logic [DTW-1:0]               dt_rise,
  output logic [DTW-1:0]               dt_fall
);
  logic [CW-1:0]  term_q, term_d;
  logic [CW-1:0]  phase_q, phase_d;
  mode_t          mode_q, mode_d;
  logic [DTW-1:0] dtr_q, dtr_d, dtf_q, dtf_d;

  always_comb begin
    term_d  = term_q;
    phase_d = phase_q;
    mode_d  = mode_q;
    dtr_d   = dtr_q;
    dtf_d   = dtf_q;
    if (wr_en) begin
      case (wr_addr)
        RA_TERM:  term_d  = wr_data;
        RA_PHASE: phase_d = wr_data;
        RA_MODE:  mode_d  = mode_t'(wr_data[MODE_W-1:0]);
        RA_DTR:   dtr_d   = wr_data[DTW-1:0];
        RA_DTF:   dtf_d   = wr_data[DTW-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q  <= '0;
      phase_q <= '0;
      mode_q  <= '0;
      dtr_q   <= '0;
      dtf_q   <= '0;
    end else begin
      term_q  <= term_d;
      phase_q <= phase_d;
      mode_q  <= mode_d;
      dtr_q   <= dtr_d;
      dtf_q   <= dtf_d;
    end
  end

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(RA_CMP1) + gi);
    logic [CW-1:0] val_q, val_d;
    always_comb val_d = (wr_en && (wr_addr == MY_ADDR)) ? wr_data : val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end
    assign cmp_val[gi] = val_q;
  end

  assign term_sh  = term_q;
  assign phase_sh = phase_q;
  assign mode     = mode_q;
  assign dt_rise  = dtr_q;
  assign dt_fall  = dtf_q;
endmodule

// File: rtl/pwm_master.sv
module pwm_master #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] term_sh,
  input  logic [CW-1:0] phase_sh,
  output logic [CW-1:0] term_act,
  output logic          wrap_ev,
  output logic          phase_ev
);
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CW-1:0] term_q, term_d, phase_q, phase_d;
  logic          load_sh;

  always_comb begin
    cnt_inc  = (cnt_q == term_q) ? '0 : cnt_q + 1'b1;
    wrap_ev  = en && (cnt_q == term_q);
    phase_ev = en && (cnt_inc == phase_q);
    cnt_d    = en ? cnt_inc : '0;
    load_sh  = wrap_ev || !en;
    term_d   = load_sh ? term_sh  : term_q;
    phase_d  = load_sh ? phase_sh : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      term_q  <= '0;
      phase_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      term_q  <= term_d;
      phase_q <= phase_d;
    end
  end

  assign term_act = term_q;

  // R3
  phase_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |-> ($past(wrap_ev) || !$past(en)));

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(wrap_ev)) |-> (cnt_q == $past(cnt_q) + 1'b1));

  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrap_ev) |-> (cnt_q == '0));
endmodule

// File: rtl/pwm_follower.sv
module pwm_follower
  import pwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       restart,
  input  logic [CW-1:0]              term_act,
  input  logic [NUM_CMP-1:0][CW-1:0] cmp_val,
  input  mode_t                      mode,
  output logic                       wave
);
  logic [CW-1:0]    cnt_q, cnt_d, cnt_inc;
  logic [NUM_CMP-1:0] hit;
  logic [NUM_CMP:0]   hit_idx;
  logic             set_hit, rst_hit;
  logic             wave_q, wave_d;

  always_comb cnt_inc = (cnt_q == term_act) ? '0 : cnt_q + 1'b1;

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_match
    assign hit[gi] = en && ((cnt_inc == cmp_val[gi]) ||
                            (restart && (cmp_val[gi] == '0)));
  end

  always_comb begin
    hit_idx = {hit, 1'b0};
    set_hit = hit_idx[mode.set_unit];
    rst_hit = hit_idx[mode.rst_unit];
    cnt_d   = (!en || restart) ? '0 : cnt_inc;
    if (!en)                     wave_d = 1'b0;
    else if (set_hit && rst_hit) wave_d = (mode.set_unit >= mode.rst_unit);
    else if (set_hit)            wave_d = 1'b1;
    else if (rst_hit)            wave_d = 1'b0;
    else                         wave_d = wave_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wave_q <= wave_d;
    end
  end

  assign wave = wave_q;

  // R4
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> (cnt_q == '0));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && rst_hit && (mode.set_unit > mode.rst_unit)) |=> wave_q);

  // R6
  rst_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && rst_hit && (mode.set_unit < mode.rst_unit)) |=> !wave_q);
endmodule

// File: rtl/pwm_deadtime.sv
module pwm_deadtime #(
  parameter int unsigned DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           wave,
  input  logic [DTW-1:0] dt_rise,
  input  logic [DTW-1:0] dt_fall,
  output logic           pwm_hi,
  output logic           pwm_lo
);
  logic           lvl_q, lvl_d;
  logic [DTW-1:0] gap_q, gap_d;
  logic           edge_seen;

  always_comb begin
    edge_seen = (wave != lvl_q);
    lvl_d     = en ? wave : 1'b0;
    if (!en)             gap_d = '0;
    else if (edge_seen)  gap_d = wave ? dt_rise : dt_fall;
    else if (gap_q != 0) gap_d = gap_q - 1'b1;
    else                 gap_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      gap_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      gap_q <= gap_d;
    end
  end

  assign pwm_hi = en &&  lvl_q && (gap_q == '0);
  assign pwm_lo = en && !lvl_q && (gap_q == '0);

  // R8
  rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dt_rise != '0) && $fell(pwm_lo)) |-> !pwm_hi);

  // R8
  fall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dt_fall != '0) && $fell(pwm_hi)) |-> !pwm_lo);
endmodule

// File: rtl/phase_pwm_timer.sv
module phase_pwm_timer
  import pwm_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned DTW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic              pwm_hi,
  output logic              pwm_lo
);
  logic [CW-1:0]              term_sh, phase_sh, term_act;
  logic [NUM_CMP-1:0][CW-1:0] cmp_val;
  mode_t                      mode;
  logic [DTW-1:0]             dt_rise, dt_fall;
  logic                       wrap_ev, phase_ev, restart, wave;

  pwm_regs #(.CW(CW), .DTW(DTW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .term_sh(term_sh), .phase_sh(phase_sh),
    .cmp_val(cmp_val), .mode(mode), .dt_rise(dt_rise), .dt_fall(dt_fall)
  );

  pwm_master #(.CW(CW)) master_i (
    .clk(clk), .rst_n(rst_n), .en(en), .term_sh(term_sh),
    .phase_sh(phase_sh), .term_act(term_act), .wrap_ev(wrap_ev),
    .phase_ev(phase_ev)
  );

  assign restart = mode.restart_on_phase ? phase_ev : wrap_ev;

  pwm_follower #(.CW(CW)) follow_i (
    .clk(clk), .rst_n(rst_n), .en(en), .restart(restart),
    .term_act(term_act), .cmp_val(cmp_val), .mode(mode), .wave(wave)
  );

  pwm_deadtime #(.DTW(DTW)) dead_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wave(wave), .dt_rise(dt_rise),
    .dt_fall(dt_fall), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );
endmodule

// File: tb/phase_pwm_timer_tb_top.sv
module phase_pwm_timer_tb_top;
  localparam int CW   = 16;
  localparam int TERM = 199;
  localparam int PLEN = TERM + 1;
  localparam int HALF = PLEN / 2;

  logic clk = 1'b0;
  logic rst_n, en, wr_en;
  logic [2:0] wr_addr;
  logic [CW-1:0] wr_data;
  logic pwm_hi, pwm_lo;

  always #4 clk = ~clk;

  phase_pwm_timer #(.CW(CW), .DTW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  int n_cmp = 0, n_bad = 0;
  int bm = 0;
  int cyc = 0;
  int overlap = 0;
  int hi_run = 0, lo_run = 0;
  int hi_rise_cnt = 0, hi_fall_cnt = 0, lo_rise_cnt = 0, lo_fall_cnt = 0;
  int hi_rise_bm = 0, hi_rise_cyc = 0, hi_len = 0, lo_rise_bm = 0, lo_len = 0;
  int win_hi_min = 0, win_hi_max = 0, win_lo_max = 0;
  int max_hi_all = 0;
  logic hi_prev = 1'b0, lo_prev = 1'b0;
  bit done = 1'b0;

  // bench model of the reference count, from R1 and R7
  always @(posedge clk) begin
    if (!rst_n || !en) bm <= 0;
    else               bm <= (bm == TERM) ? 0 : bm + 1;
  end

  always @(negedge clk) begin
    cyc++;
    if (pwm_hi && pwm_lo) overlap++;
    if (pwm_hi && !hi_prev) begin
      hi_rise_cnt++; hi_rise_bm = bm; hi_rise_cyc = cyc; hi_run = 1;
    end else if (pwm_hi) hi_run++;
    if (!pwm_hi && hi_prev) begin
      hi_fall_cnt++; hi_len = hi_run;
      if (hi_run < win_hi_min) win_hi_min = hi_run;
      if (hi_run > win_hi_max) win_hi_max = hi_run;
      if (hi_run > max_hi_all) max_hi_all = hi_run;
    end
    if (pwm_lo && !lo_prev) begin
      lo_rise_cnt++; lo_rise_bm = bm; lo_run = 1;
    end else if (pwm_lo) lo_run++;
    if (!pwm_lo && lo_prev) begin
      lo_fall_cnt++; lo_len = lo_run;
      if (lo_run > win_lo_max) win_lo_max = lo_run;
    end
    hi_prev = pwm_hi;
    lo_prev = pwm_lo;
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_le(input string tag, input int got, input int lim);
    n_cmp++;
    if (got > lim) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected at most %0d", tag, got, lim);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    step();
    wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_hi_rise();
    int c0 = hi_rise_cnt;
    while (hi_rise_cnt == c0) @(negedge clk);
  endtask
  task automatic wait_hi_fall();
    int c0 = hi_fall_cnt;
    while (hi_fall_cnt == c0) @(negedge clk);
  endtask
  task automatic wait_lo_rise();
    int c0 = lo_rise_cnt;
    while (lo_rise_cnt == c0) @(negedge clk);
  endtask
  task automatic wait_lo_fall();
    int c0 = lo_fall_cnt;
    while (lo_fall_cnt == c0) @(negedge clk);
  endtask

  task automatic win_clear();
    win_hi_min = 1 << 30; win_hi_max = 0; win_lo_max = 0;
  endtask

  function automatic int exp_hi_rise(input int ph, input int dtr);
    return (ph + 1 + dtr) % PLEN;
  endfunction
  function automatic int exp_lo_rise(input int ph, input int dtf);
    return (ph + HALF + 1 + dtf) % PLEN;
  endfunction

  // disable, program mode/units/delays/phase, enable again
  task automatic setup(input int mode, input int c1, input int c3,
                       input int ph, input int dtr, input int dtf);
    step(); en = 1'b0;
    wr(3'd0, TERM);
    wr(3'd5, mode);
    wr(3'd2, c1);
    wr(3'd3, 0);
    wr(3'd4, c3);
    wr(3'd6, dtr);
    wr(3'd7, dtf);
    wr(3'd1, ph);
    step(); en = 1'b1;
  endtask

  initial begin
    int rv, ph, dtr, dtf, c0;
    rst_n = 1'b0; en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    idle(4);
    @(negedge clk);
    chk("R7 reset hi", pwm_hi, 0);
    chk("R7 reset lo", pwm_lo, 0);
    step(); rst_n = 1'b1;

    // mode 0x0F: restart on phase, set unit 3 (value 0), reset unit 1 (half)
    setup(5'h0F, HALF, 0, 140, 6, 4);
    idle(3 * PLEN);
    wait_hi_rise(); chk("R4 rise at phase 70%", hi_rise_bm, exp_hi_rise(140, 6));
    c0 = hi_rise_cyc;
    wait_hi_fall(); chk("R8 hi width", hi_len, HALF - 6);
    wait_lo_rise(); chk("R8 lo rise", lo_rise_bm, exp_lo_rise(140, 4));
    wait_lo_fall(); chk("R8 lo width", lo_len, HALF - 4);
    wait_hi_rise(); chk("R1 period spacing", hi_rise_cyc - c0, PLEN);

    // R9 step 70% -> 30%
    win_clear(); wr(3'd1, 60); idle(4 * PLEN);
    chk("R9 70to30 min hi", win_hi_min, HALF - 6);
    chk("R9 70to30 max hi", win_hi_max, HALF - 6);
    wait_hi_rise(); chk("R4 rise at phase 30%", hi_rise_bm, exp_hi_rise(60, 6));

    // R5/R9 step 10% -> 80%: set relies on natural wrap matching value 0
    wr(3'd1, 20); idle(3 * PLEN);
    win_clear(); wr(3'd1, 160); idle(4 * PLEN);
    chk("R5 10to80 min hi", win_hi_min, HALF - 6);
    chk("R9 10to80 max hi", win_hi_max, HALF - 6);
    wait_hi_rise(); chk("R4 rise at phase 80%", hi_rise_bm, exp_hi_rise(160, 6));

    // R6 half-period step, set unit 3 outranks reset unit 1
    wr(3'd1, 10); idle(3 * PLEN);
    win_clear(); wr(3'd1, 10 + HALF); idle(4 * PLEN);
    chk("R6 set wins: longest hi", win_hi_max, PLEN - 6);
    chk_le("R9 hi within period", win_hi_max, PLEN);

    // R6 half-period step, reset unit 3 outranks set unit 1 (mode 0x1B)
    setup(5'h1B, 0, HALF, 10, 6, 4);
    idle(3 * PLEN);
    win_clear(); wr(3'd1, 10 + HALF); idle(4 * PLEN);
    chk("R6 reset wins: longest lo", win_lo_max, PLEN - 4);
    chk("R6 reset wins: longest hi", win_hi_max, HALF - 6);

    // R3 phase write mid-period waits for the wrap
    setup(5'h0F, HALF, 0, 50, 6, 4);
    idle(3 * PLEN);
    @(negedge clk); while (bm != 60) @(negedge clk);
    win_clear(); wr(3'd1, 120);
    wait_hi_rise(); chk("R3 old phase kept", hi_rise_bm, exp_hi_rise(50, 6));
    wait_hi_rise(); chk("R3 new phase after wrap", hi_rise_bm, exp_hi_rise(120, 6));
    idle(2 * PLEN);
    chk_le("R9 stretched hi within period", win_hi_max, PLEN);

    // R4 restart on reference wrap (mode 0x0E)
    setup(5'h0E, HALF, 0, 77, 3, 5);
    idle(3 * PLEN);
    wait_hi_rise(); chk("R4 wrap restart rise", hi_rise_bm, exp_hi_rise(0, 3));

    // R7 enable low mid-pulse, then counters restart from zero
    wait_hi_rise(); idle(5);
    en = 1'b0;
    @(negedge clk);
    chk("R7 disabled hi", pwm_hi, 0);
    chk("R7 disabled lo", pwm_lo, 0);
    idle(37); en = 1'b1;
    wait_hi_rise(); chk("R7 restart from zero", hi_rise_bm, exp_hi_rise(0, 3));

    // R2/R4/R8 random phases and delays, fixed seed
    setup(5'h0F, HALF, 0, 100, 6, 4);
    rv = $urandom(32'd4711);
    for (int k = 0; k < 8; k++) begin
      ph  = 3 + int'($urandom % (PLEN - 3));
      dtr = int'($urandom % 12);
      dtf = int'($urandom % 12);
      wr(3'd6, dtr); wr(3'd7, dtf); wr(3'd1, ph);
      idle(3 * PLEN);
      wait_hi_rise(); chk("R4 random rise", hi_rise_bm, exp_hi_rise(ph, dtr));
      wait_hi_fall(); chk("R2 random hi width", hi_len, HALF - dtr);
      wait_lo_rise(); chk("R8 random lo rise", lo_rise_bm, exp_lo_rise(ph, dtf));
      wait_lo_fall(); chk("R8 random lo width", lo_len, HALF - dtf);
    end

    chk("R8 overlap clocks", overlap, 0);
    chk_le("R9 longest hi overall", max_hi_all, PLEN);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule